// File: doc/BRIEF.md
# UART interrupt identification unit

This block sits beside the receive and transmit datapaths of a 16550-style serial controller and decides which interrupt, if any, the host should service next. It latches the event-type sources (line status errors, character timeout, modem status change, transmit holding register going empty) and combines them with the live received-data-at-trigger level. Each source is masked by its enable bit. It then reports the single highest-priority pending source as a code in an 8-bit identification value and drives one interrupt request line.

The host driver reads the identification value in a loop until the "no interrupt" bit reads 1. After each read it services the reported source through the access that clears it: a line status read, a modem status read, a receive buffer read, a holding register write, or the identification read itself for the transmit-empty case. Because the identification value is formed combinationally from the latched flags, the next pending source shows up in the cycle after the clearing access.

Top module: `uart_irq_ident`

## Requirements
- R1: `ident[0]` is 0 while any enabled source is pending and 1 when none is; `irq` is never high while `ident[0]` is 1.
- R2: `ident[3:0]` carries the source code: 0x6 line status, 0x4 received data at trigger, 0xC character timeout, 0x2 transmit holding empty, 0x0 modem status, 0x1 with nothing pending.
- R3: `ident[7:6]` read 11 while `fifo_on` is 1 and 00 while it is 0; bits 5:4 read 0.
- R4: `enables` bit 0 unmasks received data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. A masked source keeps its latched state but neither shows in `ident` nor raises `irq`.
- R5: `irq` is low whenever `irq_gate` is 0, even with a source pending.
- R6: The order from highest to lowest is line status, received data, character timeout, transmit empty, modem status.
- R7: The transmit-empty flag sets on a rising edge of `tx_empty`. A `hold_wr` clears it, and so does an `ident_rd` taken while `ident[3:0]` reports 0x2. An `ident_rd` taken while another code is reported leaves it set.
- R8: The line status flag sets on `ls_event` and clears on `lsr_rd`; the modem flag sets on `ms_event` and clears on `msr_rd`.
- R9: The received-data source follows the `rx_at_trig` level directly. The timeout flag sets on `tmo_event` and clears on `rbr_rd`.
- R10: When a flag's set and its clear arrive in the same cycle, the flag ends set.
- R11: After a clearing access, `ident` reports the next pending source from the next cycle on.
- R12: Reset leaves every flag clear, with `ident` = 0x01 and `irq` low. A `tx_empty` held high through reset does not raise transmit empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ls_event | input | 1 | Pulse: receiver line error detected |
| tmo_event | input | 1 | Pulse: receive character timeout expired |
| ms_event | input | 1 | Pulse: modem status input changed |
| rx_at_trig | input | 1 | Level: receive FIFO at or above trigger |
| tx_empty | input | 1 | Level: holding register or transmit FIFO empty |
| enables | input | IER_W | Interrupt enable register |
| fifo_on | input | 1 | FIFOs enabled |
| irq_gate | input | 1 | Master gate of the request line |
| ident_rd | input | 1 | Strobe: identification value read |
| hold_wr | input | 1 | Strobe: holding register write |
| lsr_rd | input | 1 | Strobe: line status register read |
| msr_rd | input | 1 | Strobe: modem status register read |
| rbr_rd | input | 1 | Strobe: receive buffer read |
| ident | output | IIR_W | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a clearing access that lands in the same cycle as a new event of a higher-priority source. The clear must act on the code being reported at that edge, not on the code that appears after it. The stimulus table reaches it by holding a transmit-empty interrupt and then pulsing `ls_event` together with `ident_rd`: the transmit flag must drop while line status takes over. A second sequence raises transmit empty while it is masked, reads the identification value, and then unmasks it, to show that a read reporting "none" cleared nothing.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   // source codes reported in the low nibble of the identification value
   localparam logic [3:0] CODE_MS   = 4'h0;
   localparam logic [3:0] CODE_NONE = 4'h1;
   localparam logic [3:0] CODE_THRE = 4'h2;
   localparam logic [3:0] CODE_RXD  = 4'h4;
   localparam logic [3:0] CODE_LS   = 4'h6;
   localparam logic [3:0] CODE_TMO  = 4'hC;

   // latched flag slots
   localparam int SLOT_LS   = 0;
   localparam int SLOT_TMO  = 1;
   localparam int SLOT_THRE = 2;
   localparam int SLOT_MS   = 3;
   localparam int NUM_SLOTS = 4;

   // enable register bit positions
   localparam int EN_RXD  = 0;
   localparam int EN_THRE = 1;
   localparam int EN_LS   = 2;
   localparam int EN_MS   = 3;

   typedef struct packed {
      logic ls;
      logic rxd;
      logic tmo;
      logic thre;
      logic ms;
   } pend_t;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R10: a set in the same cycle as a clear leaves the flag set
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   // R8: a clear with no set drops the flag
   p_clr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  pend_t      pend,
   output logic [3:0] code,
   output logic       none
);
   always_comb begin
      none = 1'b0;
      if (pend.ls)        code = CODE_LS;
      else if (pend.rxd)  code = CODE_RXD;
      else if (pend.tmo)  code = CODE_TMO;
      else if (pend.thre) code = CODE_THRE;
      else if (pend.ms)   code = CODE_MS;
      else begin
         code = CODE_MS;
         none = 1'b1;
      end
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int IER_W       = 4,
   parameter int IIR_W       = 8,
   parameter int FIFO_FLAG_W = 2,
   parameter bit HAS_TMO     = 1'b1,
   parameter bit REG_IRQ     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ls_event,
   input  logic             tmo_event,
   input  logic             ms_event,
   input  logic             rx_at_trig,
   input  logic             tx_empty,
   input  logic [IER_W-1:0] enables,
   input  logic             fifo_on,
   input  logic             irq_gate,
   input  logic             ident_rd,
   input  logic             hold_wr,
   input  logic             lsr_rd,
   input  logic             msr_rd,
   input  logic             rbr_rd,
   output logic [IIR_W-1:0] ident,
   output logic             irq
);
   localparam int CODE_W  = 4;
   localparam int FLAG_LO = IIR_W - FIFO_FLAG_W;

   generate
      if (IER_W < 4) begin : g_bad_ier
         $error("IER_W must be at least 4");
      end
      if (FIFO_FLAG_W < 1 || IIR_W < CODE_W + FIFO_FLAG_W) begin : g_bad_iir
         $error("IIR_W must hold the code nibble and the FIFO flags");
      end
   endgenerate

   logic                 tx_prev;
   logic                 thre_rise;
   logic                 tmo_set;
   logic                 thre_clr;
   logic [NUM_SLOTS-1:0] set_v;
   logic [NUM_SLOTS-1:0] clr_v;
   logic [NUM_SLOTS-1:0] flag_q;
   pend_t                pend;
   logic [3:0]           code;
   logic                 none;

   // reset to 1 so an empty transmitter at reset raises nothing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_prev <= 1'b1;
      else        tx_prev <= tx_empty;
   end
   assign thre_rise = tx_empty & ~tx_prev;

   generate
      if (HAS_TMO) begin : g_tmo
         assign tmo_set = tmo_event;
      end else begin : g_no_tmo
         assign tmo_set = 1'b0;
      end
   endgenerate

   assign thre_clr = hold_wr | (ident_rd & ~none & (code == CODE_THRE));

   always_comb begin
      set_v            = '0;
      clr_v            = '0;
      set_v[SLOT_LS]   = ls_event;
      clr_v[SLOT_LS]   = lsr_rd;
      set_v[SLOT_TMO]  = tmo_set;
      clr_v[SLOT_TMO]  = rbr_rd;
      set_v[SLOT_THRE] = thre_rise;
      clr_v[SLOT_THRE] = thre_clr;
      set_v[SLOT_MS]   = ms_event;
      clr_v[SLOT_MS]   = msr_rd;
   end

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
         uart_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[i]),
            .clr   (clr_v[i]),
            .q     (flag_q[i])
         );
      end
   endgenerate

   always_comb begin
      pend.ls   = flag_q[SLOT_LS]   & enables[EN_LS];
      pend.rxd  = rx_at_trig        & enables[EN_RXD];
      pend.tmo  = flag_q[SLOT_TMO]  & enables[EN_RXD];
      pend.thre = flag_q[SLOT_THRE] & enables[EN_THRE];
      pend.ms   = flag_q[SLOT_MS]   & enables[EN_MS];
   end

   uart_irq_prio u_prio (
      .pend (pend),
      .code (code),
      .none (none)
   );

   always_comb begin
      ident                          = '0;
      ident[CODE_W-1:0]              = code | {3'b000, none};
      ident[IIR_W-1:FLAG_LO]         = {FIFO_FLAG_W{fifo_on}};
   end

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ~none & irq_gate;
         end
         assign irq = irq_q;
         // R1: a registered request follows a pending source
         p_irq_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(!none));
      end else begin : g_irq_comb
         assign irq = ~none & irq_gate;
         // R1: request high only while the code says pending
         p_irq_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> !ident[0]);
      end
   endgenerate

   // R6: an enabled line status flag always wins
   p_ls_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[SLOT_LS] && enables[EN_LS]) |-> (ident[3:0] == CODE_LS));
   // R7: a read that reports transmit empty clears it unless a new edge arrives
   p_thre_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ident_rd && ident[3:0] == CODE_THRE && !thre_rise) |=> !flag_q[SLOT_THRE]);
   // R12: no transmit-empty flag appears without a rising edge
   p_thre_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[SLOT_THRE] && !thre_rise) |=> !flag_q[SLOT_THRE]);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
   localparam int N = 30;
   localparam int VW = 25;

   // {ls,tmo,ms events}{rx_at_trig,tx_empty}{enables}{fifo_on,irq_gate}
   // {ident_rd,hold_wr,lsr_rd,msr_rd,rbr_rd}{ident}{irq}
   localparam logic [VW-1:0] VEC [N] = '{
      {3'b000,2'b01,4'h0,2'b01,5'b00000,8'h01,1'b0}, // 0 R1 idle
      {3'b001,2'b01,4'h0,2'b01,5'b00000,8'h01,1'b0}, // 1 R4 masked modem
      {3'b000,2'b01,4'h8,2'b01,5'b00000,8'h00,1'b1}, // 2 R2 modem code
      {3'b000,2'b01,4'h8,2'b11,5'b00000,8'hC0,1'b1}, // 3 R3 fifo bits
      {3'b000,2'b01,4'h8,2'b10,5'b00000,8'hC0,1'b0}, // 4 R5 gate low
      {3'b000,2'b00,4'hF,2'b11,5'b00000,8'hC0,1'b1}, // 5 R7 tx busy
      {3'b000,2'b01,4'hF,2'b11,5'b00000,8'hC2,1'b1}, // 6 R7 empty edge
      {3'b100,2'b01,4'hF,2'b11,5'b00000,8'hC6,1'b1}, // 7 R6 line top
      {3'b000,2'b11,4'hF,2'b11,5'b00000,8'hC6,1'b1}, // 8 R6 line over data
      {3'b000,2'b11,4'hF,2'b11,5'b00100,8'hC4,1'b1}, // 9 R8 lsr read
      {3'b010,2'b11,4'hF,2'b11,5'b00000,8'hC4,1'b1}, // 10 R6 data over tmo
      {3'b000,2'b01,4'hF,2'b11,5'b00000,8'hCC,1'b1}, // 11 R9 level drop
      {3'b000,2'b01,4'hF,2'b11,5'b00001,8'hC2,1'b1}, // 12 R9 rbr read
      {3'b000,2'b01,4'hF,2'b11,5'b10000,8'hC0,1'b1}, // 13 R7 ident read
      {3'b000,2'b01,4'hF,2'b11,5'b00010,8'hC1,1'b0}, // 14 R8 msr read
      {3'b000,2'b00,4'hF,2'b11,5'b00000,8'hC1,1'b0}, // 15 R7
      {3'b000,2'b01,4'hF,2'b11,5'b00000,8'hC2,1'b1}, // 16 R7
      {3'b000,2'b01,4'hF,2'b11,5'b01000,8'hC1,1'b0}, // 17 R7 holding write
      {3'b000,2'b00,4'hF,2'b11,5'b00000,8'hC1,1'b0}, // 18 R7
      {3'b000,2'b01,4'hF,2'b11,5'b01000,8'hC2,1'b1}, // 19 R10 edge+write
      {3'b100,2'b01,4'hF,2'b11,5'b10000,8'hC6,1'b1}, // 20 R11 read+line
      {3'b100,2'b01,4'hF,2'b11,5'b00100,8'hC6,1'b1}, // 21 R10 event+read
      {3'b000,2'b01,4'hF,2'b11,5'b00100,8'hC1,1'b0}, // 22 R8
      {3'b000,2'b00,4'hD,2'b11,5'b00000,8'hC1,1'b0}, // 23 R4
      {3'b000,2'b01,4'hD,2'b11,5'b00000,8'hC1,1'b0}, // 24 R4 masked edge
      {3'b000,2'b01,4'hD,2'b11,5'b10000,8'hC1,1'b0}, // 25 R7 read of none
      {3'b000,2'b01,4'hF,2'b11,5'b00000,8'hC2,1'b1}, // 26 R4 unmask
      {3'b001,2'b01,4'hF,2'b11,5'b00000,8'hC2,1'b1}, // 27 R6 thre over modem
      {3'b000,2'b01,4'hF,2'b11,5'b10000,8'hC0,1'b1}, // 28 R11 next source
      {3'b000,2'b01,4'hF,2'b01,5'b00010,8'h01,1'b0}  // 29 R3 fifo off
   };

   function automatic string vec_req(int i);
      case (i)
         0:  return "R1";
         1, 23, 24, 26: return "R4";
         2:  return "R2";
         3, 29: return "R3";
         4:  return "R5";
         7, 8, 10, 27: return "R6";
         9, 14, 22: return "R8";
         11, 12: return "R9";
         19, 21: return "R10";
         20, 28: return "R11";
         default: return "R7";
      endcase
   endfunction

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ls_event = 0, tmo_event = 0, ms_event = 0;
   logic rx_at_trig = 0, tx_empty = 1;
   logic [3:0] enables = 4'h0;
   logic fifo_on = 0, irq_gate = 1;
   logic ident_rd = 0, hold_wr = 0, lsr_rd = 0, msr_rd = 0, rbr_rd = 0;
   logic [7:0] ident;
   logic irq;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   uart_irq_ident u_dut (
      .clk(clk), .rst_n(rst_n),
      .ls_event(ls_event), .tmo_event(tmo_event), .ms_event(ms_event),
      .rx_at_trig(rx_at_trig), .tx_empty(tx_empty), .enables(enables),
      .fifo_on(fifo_on), .irq_gate(irq_gate),
      .ident_rd(ident_rd), .hold_wr(hold_wr), .lsr_rd(lsr_rd),
      .msr_rd(msr_rd), .rbr_rd(rbr_rd),
      .ident(ident), .irq(irq)
   );

   task automatic check(string what, string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic clear_strobes();
      {ls_event, tmo_event, ms_event} = 3'b000;
      {ident_rd, hold_wr, lsr_rd, msr_rd, rbr_rd} = 5'b00000;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("ident in reset", "R12", ident, 8'h01);
      check("irq in reset", "R12", {7'b0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check("ident after reset with tx empty", "R12", ident, 8'h01);

      for (int i = 0; i < N; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         @(negedge clk);
         {ls_event, tmo_event, ms_event} = v[24:22];
         {rx_at_trig, tx_empty}          = v[21:20];
         enables                         = v[19:16];
         {fifo_on, irq_gate}             = v[15:14];
         {ident_rd, hold_wr, lsr_rd, msr_rd, rbr_rd} = v[13:9];
         @(negedge clk);
         clear_strobes();
         #1;
         check($sformatf("vector %0d ident", i), vec_req(i), ident, v[8:1]);
         check($sformatf("vector %0d irq", i), vec_req(i), {7'b0, irq}, {7'b0, v[0]});
      end

      // R12: reset in the middle of a pending modem interrupt
      @(negedge clk);
      enables = 4'h8;
      fifo_on = 1'b0;
      ms_event = 1'b1;
      @(negedge clk);
      clear_strobes();
      #1;
      check("modem pending before reset", "R2", ident, 8'h00);
      rst_n = 1'b0;
      #1;
      check("ident in mid-run reset", "R12", ident, 8'h01);
      check("irq in mid-run reset", "R12", {7'b0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check("flags stay clear after reset", "R12", ident, 8'h01);

      // R5: gate dropped while a line status interrupt is pending
      enables = 4'h4;
      ls_event = 1'b1;
      irq_gate = 1'b0;
      @(negedge clk);
      clear_strobes();
      #1;
      check("line pending with gate low", "R5", {7'b0, irq}, 8'h00);
      check("code with gate low", "R5", ident, 8'h06);
      irq_gate = 1'b1;
      #1;
      check("gate raised", "R5", {7'b0, irq}, 8'h01);
      summary();
   end
endmodule